// File: doc/BRIEF.md
# Banked Working-Register Memory with Hardware Stack

This block holds the 128-byte internal data memory of a small 8-bit controller core. The low 32 bytes double as four groups of eight working registers, and a two-bit group select picks which group a register number reaches. A sixteen-byte window starting at 20H can be changed one bit at a time. An 8-bit stack pointer grows upward through the same memory. Above the bit window the bytes are plain storage.

Each clock cycle the core issues at most one request: an operation code, an addressing mode, a group select, an address and write data. A byte can be reached in three ways. The first is by register number in the current group. The second is by direct byte address. The third is indirectly, through the first or second register of the current group acting as a pointer. Bit requests take a bit address, and stack requests use the internal pointer. Reads land in output registers at the clock edge that accepts the request. Writes take effect at that same edge. Reset is synchronous. It clears the whole memory and the read outputs, and it sets the stack pointer to 07H.

Top module: `iram_bank_stack`

## Requirements
- R1: While `rst` is high at a clock edge, every byte becomes 00H, `rdata_o` and `rbit_o` become 0, and `sp_o` becomes 07H.
- R2: Operation codes on `op_i` are 0 idle, 1 byte read, 2 byte write, 3 bit set, 4 bit clear, 5 bit read, 6 push and 7 pop. Mode codes on `mode_i` are 0 register, 1 direct, 2 indirect and 3 direct. In register mode, register n (`addr_i[2:0]`) with group select g addresses byte 8·g + n.
- R3: In direct mode the byte address is `addr_i[6:0]` and `addr_i[7]` is ignored. Direct bytes 0 to 7 are therefore the same storage as registers 0 to 7 of group 0.
- R4: In indirect mode, `addr_i[0]` selects register 0 or register 1 of the current group as the pointer. The low seven bits of that register's value address the byte that is read or written.
- R5: A byte read loads `rdata_o` at the edge that accepts it. `rdata_o` changes only on byte reads and pops, and a write is seen by any read issued after it.
- R6: Bit set and bit clear address bit (b mod 8) of byte 20H + (b div 8), where b is `addr_i[6:0]`. The other seven bits of that byte keep their values.
- R7: A bit read loads `rbit_o` with the addressed bit at the edge that accepts it, using the mapping of R6. `rbit_o` changes only on bit reads.
- R8: A push first adds one to the stack pointer and then writes `wdata_i` at the byte given by the low seven bits of the new value. The first push after reset therefore stores at 08H and leaves `sp_o` at 08H.
- R9: A pop loads `rdata_o` from the byte given by the low seven bits of the stack pointer and then subtracts one from the pointer.
- R10: The stack pointer wraps modulo 256. A pop at 00H gives FFH and a push at FFH gives 00H. Operations other than push and pop leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code for this cycle |
| mode_i | input | 2 | Byte addressing mode |
| bank_i | input | 2 | Working-register group select |
| addr_i | input | 8 | Register number, byte address, pointer select or bit address |
| wdata_i | input | 8 | Data for byte writes and pushes |
| rdata_o | output | 8 | Byte result of the last byte read or pop |
| rbit_o | output | 1 | Result of the last bit read |
| sp_o | output | 8 | Current stack pointer |

## Verification
Every result of this block is due exactly one clock edge after its request is accepted. This covers the read byte, the read bit, the new stack pointer and the written contents, which the next read can see. The bench applies each request just after a falling edge and returns the operation to idle at the next falling edge. It then compares outputs at that falling edge, half a cycle after the only edge that could have changed them. Written contents are confirmed by a later read, which is itself checked one edge after issue. Because of this, no check depends on the ordering of processes at a rising edge.

// File: rtl/iram_pkg.sv
package iram_pkg;

   typedef enum logic [2:0] {
      OP_IDLE = 3'd0,
      OP_RD   = 3'd1,
      OP_WR   = 3'd2,
      OP_BSET = 3'd3,
      OP_BCLR = 3'd4,
      OP_BRD  = 3'd5,
      OP_PUSH = 3'd6,
      OP_POP  = 3'd7
   } iram_op_e;

   typedef enum logic [1:0] {
      AM_REG  = 2'd0,
      AM_DIR  = 2'd1,
      AM_IND  = 2'd2,
      AM_DIR2 = 2'd3
   } iram_mode_e;

endpackage

// File: rtl/iram_store.sv
module iram_store #(
   parameter int DEPTH          = 128,
   parameter int DW             = 8,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW            = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [DW-1:0] rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_b
);

   logic [DW-1:0] cells [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [DW-1:0] q;
      logic          hit;
      assign hit = we && (waddr == AW'(i));
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst)      q <= '0;
            else if (hit) q <= wdata;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) q <= wdata;
         end
      end
      assign cells[i] = q;
   end

   assign rdata_a = cells[raddr_a];
   assign rdata_b = cells[raddr_b];

endmodule

// File: rtl/iram_addr_res.sv
module iram_addr_res #(
   parameter int AW     = 7,
   parameter int IN_W   = 8,
   parameter int DW     = 8,
   parameter int BANK_W = 2,
   parameter int REG_W  = 3
) (
   input  logic [1:0]        mode,
   input  logic [BANK_W-1:0] bank,
   input  logic [IN_W-1:0]   addr,
   input  logic [DW-1:0]     ptr_val,
   output logic [AW-1:0]     ptr_idx,
   output logic [AW-1:0]     ea
);
   import iram_pkg::*;

   localparam int GRP_W = BANK_W + REG_W;

   logic [GRP_W-1:0] reg_loc;
   logic [GRP_W-1:0] ptr_loc;

   assign reg_loc = {bank, addr[REG_W-1:0]};
   assign ptr_loc = {bank, {(REG_W-1){1'b0}}, addr[0]};
   assign ptr_idx = AW'(ptr_loc);

   always_comb begin
      case (iram_mode_e'(mode))
         AM_REG:  ea = AW'(reg_loc);
         AM_IND:  ea = ptr_val[AW-1:0];
         default: ea = addr[AW-1:0];
      endcase
   end

endmodule

// File: rtl/iram_bit_map.sv
module iram_bit_map #(
   parameter int AW        = 7,
   parameter int IN_W      = 8,
   parameter int DW        = 8,
   parameter int BIT_BASE  = 32,
   parameter int BIT_BYTES = 16
) (
   input  logic [IN_W-1:0]         bit_addr,
   output logic [AW-1:0]           byte_idx,
   output logic [$clog2(DW)-1:0]   bit_sel
);

   localparam int SEL_W = $clog2(DW);
   localparam int IDX_W = $clog2(BIT_BYTES * DW);
   localparam int OFF_W = IDX_W - SEL_W;

   logic [OFF_W-1:0] off;

   assign bit_sel  = bit_addr[SEL_W-1:0];
   assign off      = bit_addr[IDX_W-1:SEL_W];
   assign byte_idx = AW'(BIT_BASE) + AW'(off);

endmodule

// File: rtl/iram_sp.sv
module iram_sp #(
   parameter int SPW      = 8,
   parameter int SP_RESET = 7
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           push,
   input  logic           pop,
   output logic [SPW-1:0] sp,
   output logic [SPW-1:0] sp_inc
);

   logic [SPW-1:0] sp_q;

   assign sp_inc = sp_q + SPW'(1);
   assign sp     = sp_q;

   always_ff @(posedge clk) begin
      if (rst)       sp_q <= SPW'(SP_RESET);
      else if (push) sp_q <= sp_inc;
      else if (pop)  sp_q <= sp_q - SPW'(1);
   end

endmodule

// File: rtl/iram_bank_stack.sv
module iram_bank_stack #(
   parameter int DEPTH          = 128,
   parameter int DW             = 8,
   parameter int IN_W           = 8,
   parameter int NBANKS         = 4,
   parameter int REGS           = 8,
   parameter int BIT_BASE       = 32,
   parameter int BIT_BYTES      = 16,
   parameter int SPW            = 8,
   parameter int SP_RESET       = 7,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int BANK_W        = $clog2(NBANKS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        op_i,
   input  logic [1:0]        mode_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [IN_W-1:0]   addr_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [DW-1:0]     rdata_o,
   output logic              rbit_o,
   output logic [SPW-1:0]    sp_o
);
   import iram_pkg::*;

   localparam int AW    = $clog2(DEPTH);
   localparam int REG_W = $clog2(REGS);
   localparam int SEL_W = $clog2(DW);

   if ((1 << AW) != DEPTH) begin : g_chk_depth
      $error("DEPTH must be a power of two");
   end
   if (NBANKS * REGS > BIT_BASE) begin : g_chk_banks
      $error("register groups overlap the bit window");
   end
   if (BIT_BASE + BIT_BYTES > DEPTH) begin : g_chk_bits
      $error("bit window exceeds memory");
   end
   if (SPW < AW || IN_W <= AW) begin : g_chk_widths
      $error("pointer or address input narrower than memory index");
   end

   iram_op_e         op;
   logic [DW-1:0]    ptr_val;
   logic [AW-1:0]    ptr_idx;
   logic [AW-1:0]    ea;
   logic [AW-1:0]    bit_byte;
   logic [SEL_W-1:0] bit_sel;
   logic [SPW-1:0]   sp;
   logic [SPW-1:0]   sp_inc;
   logic [AW-1:0]    rd_addr;
   logic [DW-1:0]    rd_val;
   logic             we;
   logic [AW-1:0]    waddr;
   logic [DW-1:0]    wval;
   logic [DW-1:0]    bit_mask;
   logic [DW-1:0]    rdata_q;
   logic             rbit_q;

   assign op = iram_op_e'(op_i);

   iram_addr_res #(
      .AW(AW), .IN_W(IN_W), .DW(DW), .BANK_W(BANK_W), .REG_W(REG_W)
   ) u_res (
      .mode    (mode_i),
      .bank    (bank_i),
      .addr    (addr_i),
      .ptr_val (ptr_val),
      .ptr_idx (ptr_idx),
      .ea      (ea)
   );

   iram_bit_map #(
      .AW(AW), .IN_W(IN_W), .DW(DW), .BIT_BASE(BIT_BASE), .BIT_BYTES(BIT_BYTES)
   ) u_bits (
      .bit_addr (addr_i),
      .byte_idx (bit_byte),
      .bit_sel  (bit_sel)
   );

   iram_sp #(
      .SPW(SPW), .SP_RESET(SP_RESET)
   ) u_sp (
      .clk    (clk),
      .rst    (rst),
      .push   (op == OP_PUSH),
      .pop    (op == OP_POP),
      .sp     (sp),
      .sp_inc (sp_inc)
   );

   always_comb begin
      case (op)
         OP_BSET, OP_BCLR, OP_BRD: rd_addr = bit_byte;
         OP_POP:                   rd_addr = sp[AW-1:0];
         default:                  rd_addr = ea;
      endcase
   end

   assign bit_mask = DW'(1) << bit_sel;

   always_comb begin
      we    = 1'b0;
      waddr = ea;
      wval  = wdata_i;
      case (op)
         OP_WR: we = 1'b1;
         OP_BSET: begin
            we    = 1'b1;
            waddr = bit_byte;
            wval  = rd_val | bit_mask;
         end
         OP_BCLR: begin
            we    = 1'b1;
            waddr = bit_byte;
            wval  = rd_val & ~bit_mask;
         end
         OP_PUSH: begin
            we    = 1'b1;
            waddr = sp_inc[AW-1:0];
         end
         default: we = 1'b0;
      endcase
   end

   iram_store #(
      .DEPTH(DEPTH), .DW(DW), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .we      (we),
      .waddr   (waddr),
      .wdata   (wval),
      .raddr_a (rd_addr),
      .rdata_a (rd_val),
      .raddr_b (ptr_idx),
      .rdata_b (ptr_val)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata_q <= '0;
         rbit_q  <= 1'b0;
      end else begin
         if (op == OP_RD || op == OP_POP) rdata_q <= rd_val;
         if (op == OP_BRD)                rbit_q  <= rd_val[bit_sel];
      end
   end

   assign rdata_o = rdata_q;
   assign rbit_o  = rbit_q;
   assign sp_o    = sp;

endmodule

// File: rtl/iram_bank_stack_chk.sv
module iram_bank_stack_chk #(
   parameter int DW  = 8,
   parameter int SPW = 8
) (
   input logic           clk,
   input logic           rst,
   input logic [2:0]     op,
   input logic [SPW-1:0] sp,
   input logic [DW-1:0]  rdata,
   input logic           rbit
);

   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
      (op == 3'd6) |=> (sp == SPW'($past(sp) + SPW'(1)))); // R8

   AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
      (op == 3'd7) |=> (sp == SPW'($past(sp) - SPW'(1)))); // R9

   AST_SP_QUIET: assert property (@(posedge clk) disable iff (rst)
      (op != 3'd6 && op != 3'd7) |=> $stable(sp)); // R10

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
      (op != 3'd1 && op != 3'd7) |=> $stable(rdata)); // R5

   AST_RBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (op != 3'd5) |=> $stable(rbit)); // R7

endmodule

bind iram_bank_stack iram_bank_stack_chk #(.DW(DW), .SPW(SPW)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .op    (op_i),
   .sp    (sp_o),
   .rdata (rdata_o),
   .rbit  (rbit_o)
);

// File: tb/iram_bank_stack_test.sv
module iram_bank_stack_test;

   localparam logic [2:0] IDLE = 3'd0, RD = 3'd1, WR = 3'd2, BSET = 3'd3,
                          BCLR = 3'd4, BRD = 3'd5, PUSH = 3'd6, POP = 3'd7;
   localparam logic [1:0] MREG = 2'd0, MDIR = 2'd1, MIND = 2'd2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] op_i = IDLE;
   logic [1:0] mode_i = MDIR;
   logic [1:0] bank_i = 2'd0;
   logic [7:0] addr_i = 8'd0;
   logic [7:0] wdata_i = 8'd0;
   logic [7:0] rdata_o;
   logic       rbit_o;
   logic [7:0] sp_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   iram_bank_stack uut (
      .clk(clk), .rst(rst), .op_i(op_i), .mode_i(mode_i), .bank_i(bank_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rbit_o(rbit_o),
      .sp_o(sp_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [1:0] md, input logic [1:0] bk,
                        input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      op_i = op; mode_i = md; bank_i = bk; addr_i = a; wdata_i = d;
      @(negedge clk);
      op_i = IDLE;
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_reset();
      apply_reset();
      check("R1 sp", sp_o, 8'h07);
      check("R1 rdata", rdata_o, 0);
      check("R1 rbit", rbit_o, 0);
      issue(RD, MDIR, 0, 8'h45, 0);
      check("R1 ram", rdata_o, 0);
   endtask

   task automatic t_banks();
      for (int k = 0; k < 4; k++) issue(WR, MREG, 2'(k), 8'd3, 8'hA0 + 8'(k));
      for (int k = 0; k < 4; k++) begin
         issue(RD, MDIR, 0, 8'(k * 8 + 3), 0);
         check("R2 group map", rdata_o, 8'hA0 + 8'(k));
      end
      issue(RD, MREG, 2'd2, 8'd3, 0);
      check("R2 reg read", rdata_o, 8'hA2);
      issue(WR, MDIR, 2'd3, 8'h85, 8'h5C);
      issue(RD, MREG, 2'd0, 8'd5, 0);
      check("R3 alias bit7 ignored", rdata_o, 8'h5C);
      issue(RD, 2'd3, 2'd1, 8'h05, 0);
      check("R3 mode3 direct", rdata_o, 8'h5C);
   endtask

   task automatic t_indirect();
      issue(WR, MREG, 2'd2, 8'd1, 8'h40);
      issue(WR, MIND, 2'd2, 8'd1, 8'h5A);
      issue(RD, MDIR, 0, 8'h40, 0);
      check("R4 indirect write via reg1", rdata_o, 8'h5A);
      issue(WR, MREG, 2'd2, 8'd0, 8'hC2);
      issue(WR, MDIR, 0, 8'h42, 8'h33);
      issue(RD, MIND, 2'd2, 8'd0, 0);
      check("R4 indirect read via reg0 low7", rdata_o, 8'h33);
   endtask

   task automatic t_bits();
      issue(WR, MDIR, 0, 8'h20, 8'h00);
      issue(BSET, MDIR, 0, 8'h05, 0);
      issue(RD, MDIR, 0, 8'h20, 0);
      check("R6 set bit 05", rdata_o, 8'h20);
      issue(WR, MDIR, 0, 8'h2F, 8'hFF);
      issue(BCLR, MDIR, 0, 8'h7F, 0);
      issue(RD, MDIR, 0, 8'h2F, 0);
      check("R6 clear bit 7F", rdata_o, 8'h7F);
      issue(WR, MDIR, 0, 8'h27, 8'h81);
      issue(BSET, MREG, 2'd3, 8'h3A, 0);
      issue(RD, MDIR, 0, 8'h27, 0);
      check("R6 set bit 3A keeps others", rdata_o, 8'h85);
      issue(BRD, MDIR, 0, 8'h3A, 0);
      check("R7 read set bit", rbit_o, 1);
      issue(RD, MDIR, 0, 8'h20, 0);
      check("R7 rbit holds", rbit_o, 1);
      issue(BRD, MDIR, 0, 8'h3B, 0);
      check("R7 read clear bit", rbit_o, 0);
   endtask

   task automatic t_hold();
      issue(RD, MDIR, 0, 8'h27, 0);
      issue(WR, MDIR, 0, 8'h27, 8'h11);
      check("R5 rdata holds over write", rdata_o, 8'h85);
      issue(RD, MDIR, 0, 8'h27, 0);
      check("R5 write then read", rdata_o, 8'h11);
   endtask

   task automatic t_stack();
      apply_reset();
      issue(PUSH, MDIR, 0, 0, 8'h11);
      check("R8 first push sp", sp_o, 8'h08);
      issue(RD, MDIR, 0, 8'h08, 0);
      check("R8 first push slot", rdata_o, 8'h11);
      check("R10 sp unchanged by read", sp_o, 8'h08);
      issue(PUSH, MDIR, 0, 0, 8'h22);
      check("R8 second push sp", sp_o, 8'h09);
      issue(POP, MDIR, 0, 0, 0);
      check("R9 pop data", rdata_o, 8'h22);
      check("R9 pop sp", sp_o, 8'h08);
      issue(POP, MDIR, 0, 0, 0);
      check("R9 pop data 2", rdata_o, 8'h11);
      check("R9 pop sp 2", sp_o, 8'h07);
   endtask

   task automatic t_wrap();
      for (int i = 0; i < 8; i++) issue(POP, MDIR, 0, 0, 0);
      check("R10 wrap down", sp_o, 8'hFF);
      issue(PUSH, MDIR, 0, 0, 8'h77);
      check("R10 wrap up", sp_o, 8'h00);
      issue(RD, MDIR, 0, 8'h00, 0);
      check("R8 push after wrap slot", rdata_o, 8'h77);
   endtask

   task automatic t_reset_clear();
      issue(WR, MDIR, 0, 8'h50, 8'hEE);
      issue(BRD, MDIR, 0, 8'h3A, 0);
      apply_reset();
      check("R1 rbit cleared", rbit_o, 0);
      issue(RD, MDIR, 0, 8'h50, 0);
      check("R1 ram cleared", rdata_o, 0);
      issue(RD, MDIR, 0, 8'h27, 0);
      check("R1 bit window cleared", rdata_o, 0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      t_reset();
      t_banks();
      t_indirect();
      t_bits();
      t_hold();
      t_stack();
      t_wrap();
      t_reset_clear();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
      end
   end

endmodule